// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a synthesizable model of a synchronous burst static RAM with a small internal array and a 4-byte data word. On every rising clock edge it samples three chip enables, two address strobes, an advance input and the write controls. From these it decodes one cycle: begin a burst, step to the next burst address, hold the current address, deselect, or do nothing. Each begin, step or hold cycle is either a read or a byte-masked write.

A burst covers four words. The two low address bits follow either a linear or an interleaved order, chosen when the burst begins, and the fifth access wraps back to the start word. Read data reaches the outputs in one of two ways. In flow-through mode it bypasses the output register. In pipeline mode a rising-edge register delays it by one clock. An active-low output enable gates the data drivers without a clock.

The bidirectional data bus is split into `wdata`, `rdata` and a drive-enable output `rdata_en`, which the surrounding pad logic uses.

Top module: `sburst_sram`

## Requirements
- R1: While `rst` is high, and after it falls until the first read, `rdata_en` is 0 and `rdata` is 0.
- R2: Suppose `proc_n`=0, `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at an edge. That edge begins a read burst at `addr`, whatever `all_wr_n`, `byte_wr_n` and `be_n` are, and the array is not written.
- R3: With `cs1_n`=1, `proc_n`=0 starts no cycle. If `ctrl_n`=1 and a burst is open, the cycle continues or holds that burst. If no burst is open, nothing happens and the bus stays undriven.
- R4: Suppose `ctrl_n`=0, `proc_n`=1 and the chip is enabled (`cs1_n`=0, `cs2`=1, `cs3_n`=0). The edge begins a burst at `addr`. It is a write when the write decode (R8) is true and a read otherwise.
- R5: An asserted strobe with the chip not enabled is a deselect. The bus is undriven from that edge on. Later cycles with both strobes high do nothing until a new burst begins.
- R6: With both strobes high and a burst open, `step_n`=0 accesses the next burst address and `step_n`=1 accesses the current one again. Read or write follows the write decode.
- R7: Let the burst start at low bits s. For the k-th access, k from 0 to 4, the two address LSBs are (s+k) mod 4 when `lin_order`=1 at the burst start, and s XOR (k mod 4) when it was 0. The upper address bits stay fixed.
- R8: The write decode is true when `all_wr_n`=0, and then all four bytes are written. It is also true when `byte_wr_n`=0 and some `be_n[i]`=0, and then only byte i (`wdata[8i+7:8i]`) is written for each such i. In every other case the cycle is a read.
- R9: For a read sampled at edge k, the data is on `rdata` after edge k when `pipe_mode`=0 and after edge k+1 when `pipe_mode`=1. Tie `pipe_mode` high for the default pipelined use.
- R10: `rdata_en` is 0 for the whole cycle that follows an edge where a write was sampled, in either mode.
- R11: `oe_n`=1 forces `rdata_en` to 0 at once, without waiting for a clock edge. A read with `oe_n`=1 still moves the burst address like any other read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs1_n | input | 1 | Chip enable, active low; also masks `proc_n` |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| proc_n | input | 1 | Read-only address strobe, active low |
| ctrl_n | input | 1 | Read/write address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all bytes, active low |
| byte_wr_n | input | 1 | Byte-write qualifier, active low |
| be_n | input | 4 | Per-byte write enables, active low |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| pipe_mode | input | 1 | 1 = pipelined output, 0 = flow-through |
| oe_n | input | 1 | Output enable, active low, not clocked |
| rdata | output | 32 | Read data, 0 when not driven |
| rdata_en | output | 1 | Data drivers on |

## Verification
The array is first filled through single writes that use the controller strobe. The block is then driven with four kinds of traffic.

- Single reads through the read-only strobe, with the write inputs held active. These separate a correct read-only strobe from one that obeys the write decode.
- Four-word bursts in both orders from unaligned start words, plus suspend cycles. These separate linear from interleaved ordering, show the fifth-access wrap, and show hold cycles against steps.
- Byte-write cases with partial masks, an empty mask and a global override. These separate the two write qualifiers.
- Mode and gating cases: pipeline-versus-flow latency, masked and deselected strobes, and output-enable toggling. These check the drive rules and that counting goes on while the output is gated.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int BYTES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = BYTES * BYTE_W;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_DESEL,
        CMD_BEGIN,
        CMD_NEXT,
        CMD_HOLD
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e         kind;
        logic              is_wr;
        logic [BYTES-1:0]  mask;
    } cmd_t;

    function automatic logic [BYTES-1:0] wr_mask(input logic all_n, input logic byte_n,
                                                 input logic [BYTES-1:0] be_n);
        if (!all_n)       return '1;
        else if (!byte_n) return ~be_n;
        else              return '0;
    endfunction

    function automatic logic [1:0] burst_lo(input logic [1:0] start, input logic [1:0] cnt,
                                            input logic lin);
        return lin ? (start + cnt) : (start ^ cnt);
    endfunction
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
    import sbs_pkg::*;
(
    input  logic             active,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             proc_n,
    input  logic             ctrl_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             byte_wr_n,
    input  logic [BYTES-1:0] be_n,
    output cmd_t             cmd
);
    logic [BYTES-1:0] mask;
    logic             proc_go;
    logic             side_en;

    always_comb begin
        mask    = wr_mask(all_wr_n, byte_wr_n, be_n);
        proc_go = !proc_n && !cs1_n;
        side_en = cs2 && !cs3_n;
        cmd     = '{kind: CMD_IDLE, is_wr: 1'b0, mask: '0};
        if (proc_go) begin
            cmd.kind = side_en ? CMD_BEGIN : CMD_DESEL;
        end else if (!ctrl_n) begin
            if (!cs1_n && side_en) begin
                cmd.kind  = CMD_BEGIN;
                cmd.is_wr = |mask;
            end else begin
                cmd.kind  = CMD_DESEL;
            end
        end else if (active) begin
            cmd.kind  = step_n ? CMD_HOLD : CMD_NEXT;
            cmd.is_wr = |mask;
        end
        cmd.mask = cmd.is_wr ? mask : '0;
    end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_kind_e     kind,
    input  logic [AW-1:0] ext_addr,
    input  logic          lin_order,
    output logic [AW-1:0] cyc_addr,
    output logic          active,
    output logic [1:0]    cnt
);
    logic [AW-1:0] base;
    logic          lin_q;
    logic [1:0]    cnt_inc;

    assign cnt_inc = cnt + 2'd1;

    always_comb begin
        case (kind)
            CMD_BEGIN: cyc_addr = ext_addr;
            CMD_NEXT:  cyc_addr = {base[AW-1:2], burst_lo(base[1:0], cnt_inc, lin_q)};
            default:   cyc_addr = {base[AW-1:2], burst_lo(base[1:0], cnt, lin_q)};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base   <= '0;
            cnt    <= '0;
            lin_q  <= 1'b1;
            active <= 1'b0;
        end else begin
            case (kind)
                CMD_BEGIN: begin
                    base   <= ext_addr;
                    cnt    <= '0;
                    lin_q  <= lin_order;
                    active <= 1'b1;
                end
                CMD_NEXT:  cnt    <= cnt_inc;
                CMD_DESEL: active <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sbs_array.sv
module sbs_array
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic [BYTES-1:0]  we_mask,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        for (int b = 0; b < BYTES; b++) begin
            if (we_mask[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              proc_n,
    input  logic              ctrl_n,
    input  logic              step_n,
    input  logic              all_wr_n,
    input  logic              byte_wr_n,
    input  logic [BYTES-1:0]  be_n,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lin_order,
    input  logic              pipe_mode,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en
);
    cmd_t              cmd;
    logic              active;
    logic [1:0]        cnt;
    logic [AW-1:0]     cyc_addr;
    logic [AW-1:0]     q_addr;
    logic              q_rd, q_wr, p_rd;
    logic [DATA_W-1:0] arr_rdata, p_data;
    logic              access;

    sbs_cmd_decode u_dec (
        .active(active), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .proc_n(proc_n), .ctrl_n(ctrl_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .be_n(be_n), .cmd(cmd)
    );

    sbs_burst_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .kind(cmd.kind), .ext_addr(addr),
        .lin_order(lin_order), .cyc_addr(cyc_addr), .active(active), .cnt(cnt)
    );

    sbs_array #(.AW(AW)) u_arr (
        .clk(clk), .we_mask(cmd.mask), .waddr(cyc_addr), .wdata(wdata),
        .raddr(q_addr), .rdata(arr_rdata)
    );

    assign access = (cmd.kind == CMD_BEGIN) || (cmd.kind == CMD_NEXT) || (cmd.kind == CMD_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_addr <= '0;
            q_rd   <= 1'b0;
            q_wr   <= 1'b0;
            p_rd   <= 1'b0;
            p_data <= '0;
        end else begin
            q_addr <= cyc_addr;
            q_rd   <= access && !cmd.is_wr;
            q_wr   <= access && cmd.is_wr;
            p_rd   <= q_rd;
            p_data <= arr_rdata;
        end
    end

    logic              sel_valid;
    logic [DATA_W-1:0] sel_data;

    always_comb begin
        sel_valid = pipe_mode ? p_rd : q_rd;
        sel_data  = pipe_mode ? p_data : arr_rdata;
        rdata_en  = sel_valid && !q_wr && !oe_n;
        rdata     = rdata_en ? sel_data : '0;
    end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
    import sbs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input cmd_kind_e  kind,
    input logic       is_wr,
    input logic       proc_n,
    input logic       ctrl_n,
    input logic       cs1_n,
    input logic       oe_n,
    input logic       pipe_mode,
    input logic       active,
    input logic [1:0] cnt,
    input logic       rdata_en
);
    p_wr_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ((kind inside {CMD_BEGIN, CMD_NEXT, CMD_HOLD}) && is_wr) |=> !rdata_en);

    p_oe_gate_r11: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rdata_en);

    p_desel_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (kind == CMD_DESEL && !pipe_mode) |=> (pipe_mode || !rdata_en));

    p_hold_cnt_r6: assert property (@(posedge clk) disable iff (rst)
        (kind == CMD_HOLD) |=> $stable(cnt));

    p_next_cnt_r7: assert property (@(posedge clk) disable iff (rst)
        (kind == CMD_NEXT) |=> (cnt == $past(cnt) + 2'd1));

    p_flow_lat_r9: assert property (@(posedge clk) disable iff (rst)
        (kind == CMD_BEGIN && !is_wr && !pipe_mode) |=> (pipe_mode || oe_n || rdata_en));

    p_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (!proc_n && cs1_n && ctrl_n && !active) |=> !active);
endmodule

bind sburst_sram sbs_checker u_chk (
    .clk(clk), .rst(rst), .kind(cmd.kind), .is_wr(cmd.is_wr),
    .proc_n(proc_n), .ctrl_n(ctrl_n), .cs1_n(cs1_n), .oe_n(oe_n),
    .pipe_mode(pipe_mode), .active(active), .cnt(cnt), .rdata_en(rdata_en)
);

// File: tb/sim_sburst_sram.sv
module sim_sburst_sram;
    localparam int AW = 6;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs1_n = 1'b1, cs2 = 1'b1, cs3_n = 1'b0;
    logic proc_n = 1'b1, ctrl_n = 1'b0, step_n = 1'b1;
    logic all_wr_n = 1'b1, byte_wr_n = 1'b1;
    logic [3:0] be_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic lin_order = 1'b1, pipe_mode = 1'b0, oe_n = 1'b0;
    logic [31:0] rdata;
    logic rdata_en;

    int checks = 0;
    int errors = 0;
    logic [31:0] refm [WORDS];

    always #10 clk = ~clk;

    sburst_sram #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .proc_n(proc_n), .ctrl_n(ctrl_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .be_n(be_n),
        .addr(addr), .wdata(wdata), .lin_order(lin_order),
        .pipe_mode(pipe_mode), .oe_n(oe_n), .rdata(rdata), .rdata_en(rdata_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ref_wr(input int a, input logic [3:0] m, input logic [31:0] d);
        for (int b = 0; b < 4; b++)
            if (m[b]) refm[a][b*8 +: 8] = d[b*8 +: 8];
    endtask

    task automatic quiet_writes();
        all_wr_n = 1'b1; byte_wr_n = 1'b1; be_n = 4'hF;
    endtask

    task automatic desel();
        proc_n = 1'b1; ctrl_n = 1'b0; cs1_n = 1'b1; cs2 = 1'b1; cs3_n = 1'b0;
        quiet_writes();
        tick();
    endtask

    task automatic ctrl_cyc(input int a, input logic aw, input logic bw,
                            input logic [3:0] ben, input logic [31:0] d);
        proc_n = 1'b1; ctrl_n = 1'b0; cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        addr = a[AW-1:0]; all_wr_n = aw; byte_wr_n = bw; be_n = ben; wdata = d;
        tick();
    endtask

    task automatic cont_cyc(input logic stp, input logic aw, input logic [31:0] d);
        proc_n = 1'b1; ctrl_n = 1'b1; cs1_n = 1'b0; step_n = stp;
        all_wr_n = aw; byte_wr_n = 1'b1; be_n = 4'hF; wdata = d;
        tick();
    endtask

    task automatic see(input string req, input int a);
        chk({req, " drive"}, {31'd0, rdata_en}, 32'd1);
        chk({req, " data"}, rdata, refm[a]);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk("R1 en in reset", {31'd0, rdata_en}, 32'd0);
        chk("R1 data in reset", rdata, 32'd0);
        rst = 1'b0;
        desel();
        chk("R1 en after reset", {31'd0, rdata_en}, 32'd0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < WORDS; i++) begin
            logic [31:0] d;
            d = 32'hA500_0000 ^ (i * 32'h0103_0507);
            ctrl_cyc(i, 1'b0, 1'b1, 4'hF, d);
            ref_wr(i, 4'hF, d);
            chk("R10 write undriven", {31'd0, rdata_en}, 32'd0);
        end
        desel();
    endtask

    task automatic t_proc_read();
        int al [3] = '{3, 40, 63};
        foreach (al[j]) begin
            proc_n = 1'b0; ctrl_n = 1'b1; cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
            addr = al[j][AW-1:0]; all_wr_n = 1'b0; byte_wr_n = 1'b0; be_n = 4'h0;
            wdata = 32'hDEAD_BEEF;
            tick();
            see("R2 proc read ignores writes", al[j]);
        end
        desel();
    endtask

    task automatic t_pipe();
        pipe_mode = 1'b1;
        desel();
        proc_n = 1'b0; ctrl_n = 1'b1; cs1_n = 1'b0; addr = 6'd10;
        tick();
        chk("R9 pipe not yet", {31'd0, rdata_en}, 32'd0);
        desel();
        see("R9 pipe one later", 10);
        proc_n = 1'b0; ctrl_n = 1'b1; cs1_n = 1'b0; addr = 6'd11;
        tick();
        addr = 6'd12;
        tick();
        see("R9 pipe back to back", 11);
        ctrl_cyc(13, 1'b0, 1'b1, 4'hF, 32'h1313_1313);
        ref_wr(13, 4'hF, 32'h1313_1313);
        chk("R10 pipe write undriven", {31'd0, rdata_en}, 32'd0);
        desel();
        pipe_mode = 1'b0;
        desel();
    endtask

    task automatic t_burst(input string req, input int a, input logic lin);
        lin_order = lin;
        ctrl_cyc(a, 1'b1, 1'b1, 4'hF, 32'h0);
        see(req, a);
        for (int k = 1; k <= 4; k++) begin
            int lo;
            lo = lin ? ((a + k) % 4) : ((a % 4) ^ (k % 4));
            cont_cyc(1'b0, 1'b1, 32'h0);
            see(req, (a & ~3) | lo);
        end
        lin_order = 1'b1;
        desel();
    endtask

    task automatic t_suspend();
        ctrl_cyc(9, 1'b1, 1'b1, 4'hF, 32'h0);
        see("R6 start", 9);
        cont_cyc(1'b1, 1'b1, 32'h0);
        see("R6 hold", 9);
        cont_cyc(1'b1, 1'b1, 32'h0);
        see("R6 hold again", 9);
        cont_cyc(1'b0, 1'b1, 32'h0);
        see("R6 step", 10);
        desel();
    endtask

    task automatic t_bytes();
        ctrl_cyc(20, 1'b1, 1'b0, 4'b1010, 32'h1122_3344);
        ref_wr(20, 4'b0101, 32'h1122_3344);
        ctrl_cyc(20, 1'b1, 1'b1, 4'hF, 32'h0);
        see("R8 partial bytes", 20);
        ctrl_cyc(21, 1'b1, 1'b0, 4'hF, 32'hBAD0_BAD0);
        see("R8 empty mask reads", 21);
        ctrl_cyc(22, 1'b1, 1'b1, 4'h0, 32'hBAD1_BAD1);
        see("R8 no qualifier reads", 22);
        ctrl_cyc(23, 1'b0, 1'b0, 4'b1110, 32'h5566_7788);
        ref_wr(23, 4'hF, 32'h5566_7788);
        ctrl_cyc(23, 1'b1, 1'b1, 4'hF, 32'h0);
        see("R8 global overrides", 23);
        desel();
    endtask

    task automatic t_burst_write();
        ctrl_cyc(45, 1'b0, 1'b1, 4'hF, 32'hC0DE_0000);
        ref_wr(45, 4'hF, 32'hC0DE_0000);
        chk("R4 write begin undriven", {31'd0, rdata_en}, 32'd0);
        for (int k = 1; k < 4; k++) begin
            cont_cyc(1'b0, 1'b0, 32'hC0DE_0000 + k);
            ref_wr(44 + ((1 + k) % 4), 4'hF, 32'hC0DE_0000 + k);
            chk("R6 write step undriven", {31'd0, rdata_en}, 32'd0);
        end
        desel();
        for (int k = 0; k < 4; k++) begin
            ctrl_cyc(44 + k, 1'b1, 1'b1, 4'hF, 32'h0);
            see("R4 burst write readback", 44 + k);
        end
        desel();
    endtask

    task automatic t_mask();
        proc_n = 1'b0; ctrl_n = 1'b1; cs1_n = 1'b1; addr = 6'd30;
        tick();
        chk("R3 masked no cycle", {31'd0, rdata_en}, 32'd0);
        ctrl_cyc(50, 1'b1, 1'b1, 4'hF, 32'h0);
        see("R3 start", 50);
        proc_n = 1'b0; ctrl_n = 1'b1; cs1_n = 1'b1; step_n = 1'b0; addr = 6'd5;
        tick();
        see("R3 masked continues", 51);
        desel();
    endtask

    task automatic t_desel();
        ctrl_cyc(2, 1'b1, 1'b1, 4'hF, 32'h0);
        see("R5 start", 2);
        cs2 = 1'b0;
        tick();
        chk("R5 ctrl disabled", {31'd0, rdata_en}, 32'd0);
        cs2 = 1'b1;
        cont_cyc(1'b0, 1'b1, 32'h0);
        chk("R5 no continue", {31'd0, rdata_en}, 32'd0);
        proc_n = 1'b0; ctrl_n = 1'b1; cs1_n = 1'b0; cs3_n = 1'b1; addr = 6'd7;
        tick();
        chk("R5 proc disabled", {31'd0, rdata_en}, 32'd0);
        cs3_n = 1'b0;
        desel();
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        ctrl_cyc(56, 1'b1, 1'b1, 4'hF, 32'h0);
        chk("R11 gated", {31'd0, rdata_en}, 32'd0);
        oe_n = 1'b0;
        cont_cyc(1'b0, 1'b1, 32'h0);
        see("R11 counter advanced", 57);
        oe_n = 1'b1;
        proc_n = 1'b0; ctrl_n = 1'b1; cs1_n = 1'b0; addr = 6'd58;
        tick();
        chk("R11 gated proc", {31'd0, rdata_en}, 32'd0);
        oe_n = 1'b0;
        #1;
        see("R11 async enable", 58);
        desel();
    endtask

    initial begin
        t_reset();
        t_fill();
        t_proc_read();
        t_pipe();
        t_burst("R7 linear", 6, 1'b1);
        t_burst("R7 interleaved", 33, 1'b0);
        t_suspend();
        t_bytes();
        t_burst_write();
        t_mask();
        t_desel();
        t_oe();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule